// File: doc/BRIEF.md
# Line Status-Change Interrupt Aggregator

This block watches two 8-bit line-status vectors and folds any change in either of them into a single sticky status-change flag. The flag sits in a line-interrupt register. An active-low mask bit gates it into a one-bit summary in a global interrupt register, and that summary drives an active-low interrupt pin. Software services the interrupt by reading the line-interrupt register, which clears the flag. It then reads the two status registers.

Each status register has a snapshot that is refreshed whenever software reads that register. A companion delta register shows which bits differ between the live value and the snapshot. Software therefore sees every bit that moved since its own last read, in either direction. It does not need to keep copies of its own.

The register port takes single-cycle reads and writes. Read data is combinational from the address, and writes take effect at the clock edge.

Top module: `lsc_irq_agg`

## Requirements
- R1: A change of any bit of `stat_a` sets the status-change flag, which is bit 3 of the line-interrupt register at offset 4. The flag is visible from the first rising edge at which the new value is sampled.
- R2: A change of any bit of `stat_b` sets the same flag in the same way. Changes in both vectors in the same cycle set that single flag once.
- R3: A read of offset 4 returns the flag in bit 3, with all other bits 0. It clears the flag at that edge when neither vector changes in that cycle. Without such a read, the flag holds.
- R4: When a status change and a read of offset 4 fall in the same cycle, the flag stays set after the edge.
- R5: The line-mask register at offset 5 is a full 8-bit read/write register and resets to 0xFF. While its bit 3 is 1, the flag is masked: `irq_n` stays 1 and bit 0 of the global register at offset 6 reads 0.
- R6: While mask bit 3 is 0, global bit 0 equals the flag and `irq_n` is its inverse. Both follow the flag and the mask in the cycle those registers update.
- R7: A read of offset 0 returns live `stat_a` and stores it as that register's snapshot. Offset 1 does the same for `stat_b`. Offsets 2 and 3 return the live value XOR the snapshot for `stat_a` and `stat_b`. Reading a delta register leaves the snapshot unchanged.
- R8: After reset the flag is 0, the mask is 0xFF, `irq_n` is 1 and global bit 0 is 0. Both snapshots hold the live values, so both deltas read 0.
- R9: Writes to any offset other than 5 change no state. Offset 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_rd | input | 1 | Single-cycle register read strobe |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| stat_a | input | 8 | First live line-status vector |
| stat_b | input | 8 | Second live line-status vector |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
Read data is due in the same cycle as the strobe. The flag, the mask and the snapshots change at the edge that closes a strobe or a status change. The pin follows those registers without a further stage. The bench applies every stimulus just after a falling edge and pushes the expected value into a scoreboard queue. A monitor pops and compares it half a nanosecond before the next rising edge. A result caused by one cycle's stimulus is therefore always checked in the following bench step, never in the step that caused it. The coincident change-and-read case is checked in both of those steps.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int LSC_DATA_W  = 8;
    localparam int LSC_ADDR_W  = 3;
    localparam int LSC_NUM_SRC = 2;
    localparam int LSC_CHG_BIT = 3;
    localparam int LSC_SUM_BIT = 0;

    typedef logic [LSC_DATA_W-1:0] lsc_byte_t;

    // Register offsets; status and delta offsets are consecutive per source.
    typedef enum logic [LSC_ADDR_W-1:0] {
        RA_STAT0     = 3'd0,
        RA_STAT1     = 3'd1,
        RA_DELTA0    = 3'd2,
        RA_DELTA1    = 3'd3,
        RA_LINE_IRQ  = 3'd4,
        RA_LINE_MASK = 3'd5,
        RA_GLOBAL    = 3'd6,
        RA_SPARE     = 3'd7
    } lsc_addr_e;

    // Per-source view exported by each change detector.
    typedef struct packed {
        lsc_byte_t live;
        lsc_byte_t snap;
        lsc_byte_t delta;
    } lsc_src_view_t;

    function automatic lsc_addr_e stat_addr(input int idx);
        return lsc_addr_e'(int'(RA_STAT0) + idx);
    endfunction

    function automatic lsc_addr_e delta_addr(input int idx);
        return lsc_addr_e'(int'(RA_DELTA0) + idx);
    endfunction

    function automatic lsc_byte_t place_bit(input int pos, input logic v);
        lsc_byte_t r;
        r      = '0;
        r[pos] = v;
        return r;
    endfunction

endpackage

// File: rtl/lsc_change_det.sv
module lsc_change_det
    import lsc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  lsc_byte_t     live_i,
    input  logic          snap_load_i,
    output logic          changed_o,
    output lsc_src_view_t view_o
);

    lsc_byte_t prev_q;
    lsc_byte_t snap_q;

    // prev_q follows the input every cycle, including reset, so the
    // comparison is valid from the first edge after reset.
    always_ff @(posedge clk) begin
        prev_q <= live_i;
        if (rst || snap_load_i) begin
            snap_q <= live_i;
        end
    end

    assign changed_o    = (live_i != prev_q);
    assign view_o.live  = live_i;
    assign view_o.snap  = snap_q;
    assign view_o.delta = live_i ^ snap_q;

endmodule

// File: rtl/lsc_irq_core.sv
module lsc_irq_core
    import lsc_pkg::*;
#(
    parameter lsc_byte_t MASK_RESET = '1,
    parameter int        CHG_BIT    = LSC_CHG_BIT
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      any_change_i,
    input  logic      flag_rd_i,
    input  logic      mask_wr_i,
    input  lsc_byte_t wdata_i,
    output logic      flag_o,
    output lsc_byte_t mask_o,
    output logic      summary_o
);

    logic      flag_q;
    lsc_byte_t mask_q;

    // A change in the same cycle as a clearing read wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (any_change_i) begin
            flag_q <= 1'b1;
        end else if (flag_rd_i) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= MASK_RESET;
        end else if (mask_wr_i) begin
            mask_q <= wdata_i;
        end
    end

    assign flag_o    = flag_q;
    assign mask_o    = mask_q;
    assign summary_o = flag_q & ~mask_q[CHG_BIT];

endmodule

// File: rtl/lsc_reg_file.sv
module lsc_reg_file
    import lsc_pkg::*;
#(
    parameter int CHG_BIT = LSC_CHG_BIT,
    parameter int SUM_BIT = LSC_SUM_BIT
) (
    input  logic                   rd_i,
    input  logic                   wr_i,
    input  logic [LSC_ADDR_W-1:0]  addr_i,
    input  lsc_src_view_t          view_i [LSC_NUM_SRC],
    input  logic                   flag_i,
    input  lsc_byte_t              mask_i,
    input  logic                   summary_i,
    output lsc_byte_t              rdata_o,
    output logic [LSC_NUM_SRC-1:0] snap_load_o,
    output logic                   flag_rd_o,
    output logic                   mask_wr_o
);

    for (genvar g = 0; g < LSC_NUM_SRC; g++) begin : g_snap
        assign snap_load_o[g] = rd_i && (addr_i == stat_addr(g));
    end

    assign flag_rd_o = rd_i && (addr_i == RA_LINE_IRQ);
    assign mask_wr_o = wr_i && (addr_i == RA_LINE_MASK);

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < LSC_NUM_SRC; i++) begin
            if (addr_i == stat_addr(i)) begin
                rdata_o = view_i[i].live;
            end
            if (addr_i == delta_addr(i)) begin
                rdata_o = view_i[i].delta;
            end
        end
        case (addr_i)
            RA_LINE_IRQ:  rdata_o = place_bit(CHG_BIT, flag_i);
            RA_LINE_MASK: rdata_o = mask_i;
            RA_GLOBAL:    rdata_o = place_bit(SUM_BIT, summary_i);
            default: ;
        endcase
    end

endmodule

// File: rtl/lsc_irq_agg.sv
module lsc_irq_agg
    import lsc_pkg::*;
#(
    parameter lsc_byte_t MASK_RESET = '1,
    parameter int        CHG_BIT    = LSC_CHG_BIT,
    parameter int        SUM_BIT    = LSC_SUM_BIT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [LSC_ADDR_W-1:0] reg_addr,
    input  logic [LSC_DATA_W-1:0] reg_wdata,
    output logic [LSC_DATA_W-1:0] reg_rdata,
    input  logic [LSC_DATA_W-1:0] stat_a,
    input  logic [LSC_DATA_W-1:0] stat_b,
    output logic                  irq_n
);

    lsc_byte_t              live [LSC_NUM_SRC];
    lsc_src_view_t          view [LSC_NUM_SRC];
    logic [LSC_NUM_SRC-1:0] changed;
    logic [LSC_NUM_SRC-1:0] snap_load;
    logic                   flag_rd;
    logic                   mask_wr;
    logic                   flag_q;
    lsc_byte_t              mask_q;
    logic                   summary;

    assign live[0] = stat_a;
    assign live[1] = stat_b;

    for (genvar g = 0; g < LSC_NUM_SRC; g++) begin : g_src
        lsc_change_det u_det (
            .clk         (clk),
            .rst         (rst),
            .live_i      (live[g]),
            .snap_load_i (snap_load[g]),
            .changed_o   (changed[g]),
            .view_o      (view[g])
        );
    end

    lsc_irq_core #(
        .MASK_RESET (MASK_RESET),
        .CHG_BIT    (CHG_BIT)
    ) u_core (
        .clk          (clk),
        .rst          (rst),
        .any_change_i (|changed),
        .flag_rd_i    (flag_rd),
        .mask_wr_i    (mask_wr),
        .wdata_i      (reg_wdata),
        .flag_o       (flag_q),
        .mask_o       (mask_q),
        .summary_o    (summary)
    );

    lsc_reg_file #(
        .CHG_BIT (CHG_BIT),
        .SUM_BIT (SUM_BIT)
    ) u_regs (
        .rd_i        (reg_rd),
        .wr_i        (reg_wr),
        .addr_i      (reg_addr),
        .view_i      (view),
        .flag_i      (flag_q),
        .mask_i      (mask_q),
        .summary_i   (summary),
        .rdata_o     (reg_rdata),
        .snap_load_o (snap_load),
        .flag_rd_o   (flag_rd),
        .mask_wr_o   (mask_wr)
    );

    assign irq_n = ~summary;

endmodule

// File: rtl/lsc_irq_agg_chk.sv
module lsc_irq_agg_chk
    import lsc_pkg::*;
#(
    parameter int CHG_BIT = LSC_CHG_BIT
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_rd,
    input logic                  reg_wr,
    input logic [LSC_ADDR_W-1:0] reg_addr,
    input logic [LSC_DATA_W-1:0] stat_a,
    input logic [LSC_DATA_W-1:0] stat_b,
    input logic                  irq_n,
    input logic                  flag_q,
    input lsc_byte_t             mask_q
);

    AST_CHG_A_SETS: assert property (@(posedge clk) disable iff (rst)
        (stat_a != $past(stat_a)) |=> flag_q); // R1
    AST_CHG_B_SETS: assert property (@(posedge clk) disable iff (rst)
        (stat_b != $past(stat_b)) |=> flag_q); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == RA_LINE_IRQ && stat_a == $past(stat_a)
         && stat_b == $past(stat_b)) |=> !flag_q); // R3
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(reg_rd && reg_addr == RA_LINE_IRQ)) |=> flag_q); // R3
    AST_COINCIDENT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == RA_LINE_IRQ
         && (stat_a != $past(stat_a) || stat_b != $past(stat_b))) |=> flag_q); // R4
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        mask_q[CHG_BIT] |-> irq_n); // R5
    AST_UNMASKED_PIN: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !mask_q[CHG_BIT]) |-> !irq_n); // R6
    AST_IDLE_PIN: assert property (@(posedge clk) disable iff (rst)
        !flag_q |-> irq_n); // R6
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!flag_q && mask_q == '1 && irq_n)); // R8
    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != RA_LINE_MASK) |=> $stable(mask_q)); // R9

endmodule

bind lsc_irq_agg lsc_irq_agg_chk #(.CHG_BIT(CHG_BIT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .stat_a   (stat_a),
    .stat_b   (stat_b),
    .irq_n    (irq_n),
    .flag_q   (flag_q),
    .mask_q   (mask_q)
);

// File: tb/lsc_irq_agg_tb.sv
`timescale 1ns/100ps
module lsc_irq_agg_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] stat_a = 8'h00;
    logic [7:0] stat_b = 8'h00;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit         is_pin;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb [$];

    always #2.5 clk = ~clk;

    lsc_irq_agg u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .stat_a    (stat_a),
        .stat_b    (stat_b),
        .irq_n     (irq_n)
    );

    task automatic step(input bit rd_e, input bit wr_e, input logic [2:0] a,
                        input logic [7:0] wd, input logic [7:0] na, input logic [7:0] nb);
        @(negedge clk);
        reg_rd    = rd_e;
        reg_wr    = wr_e;
        reg_addr  = a;
        reg_wdata = wd;
        stat_a    = na;
        stat_b    = nb;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        step(1'b1, 1'b0, a, 8'h00, stat_a, stat_b);
        sb.push_back('{1'b0, exp, tag});
    endtask

    task automatic rd_chg(input logic [2:0] a, input logic [7:0] exp,
                          input logic [7:0] na, input logic [7:0] nb, input string tag);
        step(1'b1, 1'b0, a, 8'h00, na, nb);
        sb.push_back('{1'b0, exp, tag});
    endtask

    task automatic pin_chk(input logic exp, input string tag);
        step(1'b0, 1'b0, 3'd0, 8'h00, stat_a, stat_b);
        sb.push_back('{1'b1, {7'b0, exp}, tag});
    endtask

    task automatic set_stat(input logic [7:0] na, input logic [7:0] nb);
        step(1'b0, 1'b0, 3'd0, 8'h00, na, nb);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, a, d, stat_a, stat_b);
    endtask

    // Monitor: compares just before the rising edge that closes each step.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it  = sb.pop_front();
                act = it.is_pin ? {7'b0, irq_n} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        set_stat(8'h00, 8'h00);

        // R8 reset state
        rd_chk(3'd4, 8'h00, "R8 flag clear");
        rd_chk(3'd5, 8'hFF, "R8 mask reset");
        rd_chk(3'd6, 8'h00, "R8 global clear");
        rd_chk(3'd2, 8'h00, "R8 delta a");
        rd_chk(3'd3, 8'h00, "R8 delta b");
        pin_chk(1'b1, "R8 pin idle");

        // R1 with R5 masking
        set_stat(8'h01, 8'h00);
        pin_chk(1'b1, "R5 masked pin");
        rd_chk(3'd6, 8'h00, "R5 masked global");
        rd_chk(3'd4, 8'h08, "R1 flag from stat_a");
        rd_chk(3'd4, 8'h00, "R3 cleared by read");
        pin_chk(1'b1, "R3 stays clear");

        // R6 unmask, R2 change on stat_b
        wr_reg(3'd5, 8'hF7);
        rd_chk(3'd5, 8'hF7, "R5 mask readback");
        pin_chk(1'b1, "R6 idle unmasked");
        set_stat(8'h01, 8'h80);
        pin_chk(1'b0, "R6 pin asserted");
        pin_chk(1'b0, "R3 flag holds");
        rd_chk(3'd6, 8'h01, "R6 global summary");
        rd_chk(3'd4, 8'h08, "R2 flag from stat_b");
        pin_chk(1'b1, "R6 pin released");

        // R4 coincident change and read
        set_stat(8'h03, 8'h80);
        rd_chg(3'd4, 8'h08, 8'h03, 8'h81, "R4 read with change");
        rd_chk(3'd4, 8'h08, "R4 flag kept");
        rd_chk(3'd4, 8'h00, "R4 then cleared");

        // R2 both change together, one clear suffices
        set_stat(8'h13, 8'h91);
        rd_chk(3'd4, 8'h08, "R2 both changed");
        rd_chk(3'd4, 8'h00, "R2 single clear");

        // R7 snapshots and deltas
        rd_chk(3'd0, 8'h13, "R7 live a");
        set_stat(8'h5A, 8'h91);
        rd_chk(3'd2, 8'h49, "R7 delta a");
        rd_chk(3'd2, 8'h49, "R7 delta a kept");
        rd_chk(3'd0, 8'h5A, "R7 live a new");
        rd_chk(3'd2, 8'h00, "R7 delta a after read");
        rd_chk(3'd3, 8'h91, "R7 delta b since reset");
        rd_chk(3'd1, 8'h91, "R7 live b");
        rd_chk(3'd3, 8'h00, "R7 delta b after read");
        set_stat(8'h5A, 8'h6E);
        rd_chk(3'd3, 8'hFF, "R7 delta b all bits");

        // R9 ignored writes
        rd_chk(3'd4, 8'h08, "R2 flag before writes");
        wr_reg(3'd4, 8'hFF);
        rd_chk(3'd4, 8'h00, "R9 write to flag reg");
        wr_reg(3'd6, 8'hFF);
        rd_chk(3'd6, 8'h00, "R9 write to global");
        wr_reg(3'd0, 8'hAA);
        rd_chk(3'd2, 8'h00, "R9 write to status");
        rd_chk(3'd5, 8'hF7, "R9 mask untouched");
        rd_chk(3'd7, 8'h00, "R9 spare reads zero");

        // R5 re-mask with flag pending
        set_stat(8'h5B, 8'h6E);
        pin_chk(1'b0, "R6 pending unmasked");
        wr_reg(3'd5, 8'hFF);
        pin_chk(1'b1, "R5 remasked pin");
        rd_chk(3'd6, 8'h00, "R5 remasked global");

        set_stat(stat_a, stat_b);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule